// File: doc/BRIEF.md
# Masked Eight-Line Interrupt Controller

This block collects eight interrupt request lines into one pending register and presents a single level-sensitive interrupt output to the upstream interrupt fabric. Device logic posts requests through a set vector and withdraws them through a clear vector. Software reaches the block through a byte-wide register port. Through it software programs an enable mask, reads the pending bits and retires one request at a time by writing its line index.

A second, cascaded controller exists only as a stub. Its mask byte can be written and read back, but its status always reads as zero, its acknowledge writes do nothing, and it never drives the output. There is no priority resolution and no vector generation. The output is high exactly while some enabled line is pending.

The output tracking is a two-state machine. QUIET means the output is low and RAISED means it is high. The RAISE transition is taken when the next pending-and-enabled vector becomes nonzero. The DROP transition is taken when that vector returns to zero. Because the machine only moves on a change, the upstream logic never sees a repeated assert or deassert.

Top module: `irqc_top`

## Requirements
- R1: After reset the output is low, the pending register reads 0x00, the primary mask reads back 0xFF (every line disabled), the secondary mask reads 0x00 and no error is flagged.
- R2: A byte write to offset 1 stores the primary mask, where a written 1 disables that line, so the enable vector is the bitwise complement of the byte. A byte read of offset 1 returns the byte as written.
- R3: In each cycle the next pending value is formed in this order: bits in `src_set` are ORed in, then bits in `src_clr` are removed, then any acknowledge is applied. When a bit is in both vectors, the clear wins.
- R4: A byte write to offset 0 is an acknowledge. It clears the pending bit selected by `reg_wdata[3:0]`. Data bits 7:4 are ignored, and an index of 8 to 15 clears nothing.
- R5: `irq_out` is high exactly when (pending AND enable) is nonzero. It follows the edge that caused the change: a mask write, set, clear or acknowledge. A mask write that enables a pending line raises it, and one that masks every pending line drops it.
- R6: A read of offset 0 returns the pending register zero-extended in `reg_rdata`, and the same value is returned for an 8-bit access (`reg_size`=0) and a 64-bit access (`reg_size`=3). Read data appears in the cycle after the request.
- R7: A byte write to offset 3 stores the secondary mask unchanged, and a byte read of offset 3 returns it. It never affects `irq_out`. A byte read of offset 2 returns 0x00, and a byte write to offset 2 changes nothing.
- R8: A request is an error if it uses offsets 4 to 7, or if it uses any size other than one byte (`reg_size` 1=2 bytes, 2=4 bytes, 3=8 bytes). The one exception is a 64-bit read of offset 0. An error raises `reg_err` for the cycle after the request, returns zero read data and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 8 | Per-line request set vector from devices |
| src_clr | input | 8 | Per-line request clear vector from devices |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access size: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| reg_offset | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 64 | Read data, valid the cycle after a read |
| reg_err | output | 1 | Error response, one cycle after a bad request |
| irq_out | output | 1 | Level interrupt to the upstream fabric |

## Verification
A corrupt pending or enable register shows at the ports in one of two ways. It appears on `irq_out` one edge after the event that should have moved it, or in the next status or mask read. The checks therefore sample both the output and a read-back right after every set, clear, acknowledge and mask event. If the output machine is stuck in one state, `irq_out` disagrees within one cycle of the first RAISE or DROP that should have occurred. An error-path fault shows up in two places: as a flag in the wrong cycle, and as a mask or pending read-back that changed after a rejected request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register offsets
    localparam int OFF_PSTAT = 0;   // primary status (read) / acknowledge (write)
    localparam int OFF_PMASK = 1;   // primary mask, written 1 = disabled
    localparam int OFF_SSTAT = 2;   // secondary stub status / acknowledge
    localparam int OFF_SMASK = 3;   // secondary stub mask

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } out_state_e;

    typedef struct packed {
        logic pmask;
        logic smask;
        logic ack;
    } wr_strobe_t;

endpackage

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int AW  = 3,
    parameter int DW  = 8,
    parameter int RDW = 64,
    parameter int NL  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid,
    input  logic           write,
    input  logic [1:0]     size,
    input  logic [AW-1:0]  offset,
    input  logic [NL-1:0]  pend,
    input  logic [DW-1:0]  pmask_raw,
    input  logic [DW-1:0]  smask,
    output wr_strobe_t     stb,
    output logic [RDW-1:0] rdata_q,
    output logic           err_q
);

    logic           mapped;
    logic           legal;
    logic           err_d;
    logic [RDW-1:0] rd_d;

    always_comb begin
        mapped = (offset <= AW'(OFF_SMASK));
        legal  = valid && mapped &&
                 ((size == SZ_BYTE) ||
                  ((size == SZ_DWORD) && !write && (offset == AW'(OFF_PSTAT))));
        err_d  = valid && !legal;

        stb.pmask = legal && write && (offset == AW'(OFF_PMASK));
        stb.smask = legal && write && (offset == AW'(OFF_SMASK));
        stb.ack   = legal && write && (offset == AW'(OFF_PSTAT));

        rd_d = '0;
        if (legal && !write) begin
            unique case (offset)
                AW'(OFF_PSTAT): rd_d = RDW'(pend);
                AW'(OFF_PMASK): rd_d = RDW'(pmask_raw);
                AW'(OFF_SSTAT): rd_d = '0;
                AW'(OFF_SMASK): rd_d = RDW'(smask);
                default:        rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rd_d;
            err_q   <= err_d;
        end
    end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int NL   = 8,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NL-1:0]   set_vec,
    input  logic [NL-1:0]   clr_vec,
    input  logic            ack_we,
    input  logic [IDXW-1:0] ack_idx,
    output logic [NL-1:0]   pend_d,
    output logic [NL-1:0]   pend_q
);

    logic [NL-1:0] ack_hit;

    // One decoder per line; indices beyond NL-1 hit nothing
    for (genvar i = 0; i < NL; i++) begin : g_ack
        assign ack_hit[i] = ack_we && (ack_idx == IDXW'(i));
    end

    // Set, then clear, then acknowledge
    assign pend_d = ((pend_q | set_vec) & ~clr_vec) & ~ack_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/irqc_maskreg.sv
module irqc_maskreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pmask_we,
    input  logic          smask_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] en_d,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] pmask_raw,
    output logic [DW-1:0] smask_q
);

    assign en_d      = pmask_we ? ~wdata : en_q;
    assign pmask_raw = ~en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            smask_q <= '0;
        end else begin
            en_q <= en_d;
            if (smask_we) smask_q <= wdata;
        end
    end

endmodule

// File: rtl/irqc_outfsm.sv
module irqc_outfsm
    import irqc_pkg::*;
#(
    parameter int NL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] pend_d,
    input  logic [NL-1:0] en_d,
    output logic          irq_out
);

    out_state_e state_q, state_d;
    logic       any_d;

    assign any_d = |(pend_d & en_d);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // RAISE: QUIET -> RAISED, DROP: RAISED -> QUIET
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (any_d)  state_d = ST_RAISED;
            ST_RAISED: if (!any_d) state_d = ST_QUIET;
            default:               state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq_out = (state_q == ST_RAISED);
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NL   = 8,
    parameter int AW   = 3,
    parameter int RDW  = 64,
    parameter int IDXW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NL-1:0]  src_set,
    input  logic [NL-1:0]  src_clr,
    input  logic           reg_valid,
    input  logic           reg_write,
    input  logic [1:0]     reg_size,
    input  logic [AW-1:0]  reg_offset,
    input  logic [NL-1:0]  reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    output logic           reg_err,
    output logic           irq_out
);

    wr_strobe_t    stb;
    logic [NL-1:0] pend_q, pend_d;
    logic [NL-1:0] en_q, en_d;
    logic [NL-1:0] pmask_raw, smask_q;

    irqc_regif #(.AW(AW), .DW(NL), .RDW(RDW), .NL(NL)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (reg_valid),
        .write     (reg_write),
        .size      (reg_size),
        .offset    (reg_offset),
        .pend      (pend_q),
        .pmask_raw (pmask_raw),
        .smask     (smask_q),
        .stb       (stb),
        .rdata_q   (reg_rdata),
        .err_q     (reg_err)
    );

    irqc_pending #(.NL(NL), .IDXW(IDXW)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (src_set),
        .clr_vec (src_clr),
        .ack_we  (stb.ack),
        .ack_idx (reg_wdata[IDXW-1:0]),
        .pend_d  (pend_d),
        .pend_q  (pend_q)
    );

    irqc_maskreg #(.DW(NL)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .pmask_we  (stb.pmask),
        .smask_we  (stb.smask),
        .wdata     (reg_wdata),
        .en_d      (en_d),
        .en_q      (en_q),
        .pmask_raw (pmask_raw),
        .smask_q   (smask_q)
    );

    irqc_outfsm #(.NL(NL)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_d  (pend_d),
        .en_d    (en_d),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NL  = 8,
    parameter int AW  = 3,
    parameter int RDW = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NL-1:0]  src_set,
    input logic [NL-1:0]  src_clr,
    input logic           reg_valid,
    input logic           reg_write,
    input logic [1:0]     reg_size,
    input logic [AW-1:0]  reg_offset,
    input logic [RDW-1:0] reg_rdata,
    input logic           reg_err,
    input logic           irq_out,
    input logic [NL-1:0]  pend,
    input logic [NL-1:0]  en
);

    assert_irq_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(pend & en)));

    assert_err_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_valid));

    assert_err_keeps_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $stable(en));

    assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> (reg_rdata == '0));

    assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & $past(src_clr)) == '0);

    assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_valid && reg_write) |->
            ((pend & $past(src_set & ~src_clr)) == $past(src_set & ~src_clr)));

    assert_sstat_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_valid && !reg_write && (reg_size == 2'd0) && (reg_offset == AW'(2)))
            |-> (reg_rdata == '0));

endmodule

bind irqc_top irqc_checker #(.NL(NL), .AW(AW), .RDW(RDW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_set    (src_set),
    .src_clr    (src_clr),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_size   (reg_size),
    .reg_offset (reg_offset),
    .reg_rdata  (reg_rdata),
    .reg_err    (reg_err),
    .irq_out    (irq_out),
    .pend       (pend_q),
    .en         (en_q)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;

    localparam int NV = 29;
    localparam logic [1:0] IDL = 2'd0, WR = 2'd1, RD = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_set = '0, src_clr = '0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_size = '0;
    logic [2:0]  reg_offset = '0;
    logic [7:0]  reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err, irq_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_size(reg_size),
        .reg_offset(reg_offset), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .irq_out(irq_out)
    );

    // {op, size, offset, wdata, set, clr, exp_irq, exp_err, exp_rdata, req}
    function automatic logic [44:0] v(input logic [1:0] op, input logic [1:0] sz,
        input logic [2:0] off, input logic [7:0] wd, input logic [7:0] st,
        input logic [7:0] cl, input logic ei, input logic ee,
        input logic [7:0] erd, input logic [3:0] rq);
        return {op, sz, off, wd, st, cl, ei, ee, erd, rq};
    endfunction

    localparam logic [44:0] VECS [0:NV-1] = '{
        v(RD,  0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 1), // R1 pending empty
        v(RD,  0, 1, 8'h00, 8'h00, 8'h00, 0, 0, 8'hFF, 1), // R1 all masked
        v(IDL, 0, 0, 8'h00, 8'h05, 8'h00, 0, 0, 8'h00, 5), // R5 masked pend
        v(WR,  0, 1, 8'hFE, 8'h00, 8'h00, 1, 0, 8'h00, 5), // R5 unmask raises
        v(RD,  0, 1, 8'h00, 8'h00, 8'h00, 1, 0, 8'hFE, 2), // R2 readback
        v(RD,  3, 0, 8'h00, 8'h00, 8'h00, 1, 0, 8'h05, 6), // R6 64-bit read
        v(WR,  0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 4), // R4 ack line 0
        v(WR,  0, 1, 8'hFB, 8'h00, 8'h00, 1, 0, 8'h00, 2), // R2 enable line 2
        v(WR,  0, 0, 8'h08, 8'h00, 8'h00, 1, 0, 8'h00, 4), // R4 index 8 no-op
        v(WR,  0, 0, 8'h12, 8'h00, 8'h00, 0, 0, 8'h00, 4), // R4 high bits ignored
        v(IDL, 0, 0, 8'h00, 8'h10, 8'h10, 0, 0, 8'h00, 3), // R3 clear wins
        v(IDL, 0, 0, 8'h00, 8'h24, 8'h00, 1, 0, 8'h00, 3), // R3 set
        v(IDL, 0, 0, 8'h00, 8'h00, 8'h04, 0, 0, 8'h00, 3), // R3 clear
        v(RD,  0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h20, 6), // R6 byte read
        v(WR,  0, 3, 8'h5A, 8'h00, 8'h00, 0, 0, 8'h00, 7), // R7 smask write
        v(RD,  0, 3, 8'h00, 8'h00, 8'h00, 0, 0, 8'h5A, 7), // R7 smask read
        v(RD,  0, 2, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 7), // R7 sstat zero
        v(WR,  0, 2, 8'h05, 8'h00, 8'h00, 0, 0, 8'h00, 7), // R7 sack ignored
        v(RD,  0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h20, 7), // R7 pend intact
        v(WR,  1, 0, 8'h05, 8'h00, 8'h00, 0, 1, 8'h00, 8), // R8 2-byte write
        v(RD,  3, 1, 8'h00, 8'h00, 8'h00, 0, 1, 8'h00, 8), // R8 64-bit mask rd
        v(RD,  0, 5, 8'h00, 8'h00, 8'h00, 0, 1, 8'h00, 8), // R8 unmapped read
        v(WR,  0, 6, 8'h00, 8'h00, 8'h00, 0, 1, 8'h00, 8), // R8 unmapped write
        v(RD,  0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h20, 8), // R8 no change
        v(WR,  3, 1, 8'h00, 8'h00, 8'h00, 0, 1, 8'h00, 8), // R8 64-bit write
        v(WR,  0, 1, 8'h00, 8'h00, 8'h00, 1, 0, 8'h00, 5), // R5 enable all
        v(WR,  0, 0, 8'h00, 8'h01, 8'h00, 1, 0, 8'h00, 3), // R3 ack after set
        v(RD,  0, 0, 8'h00, 8'h00, 8'h00, 1, 0, 8'h20, 3), // R3 result
        v(WR,  0, 1, 8'hFF, 8'h00, 8'h00, 0, 0, 8'h00, 5)  // R5 mask all drops
    };

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [1:0] sz,
                         input logic [2:0] off, input logic [7:0] wd,
                         input logic [7:0] st, input logic [7:0] cl);
        reg_valid  = (op != IDL);
        reg_write  = (op == WR);
        reg_size   = sz;
        reg_offset = off;
        reg_wdata  = wd;
        src_set    = st;
        src_clr    = cl;
    endtask

    task automatic read_chk(input logic [2:0] off, input logic [1:0] sz,
                            input logic [63:0] exp, input string rq);
        @(negedge clk);
        drive(RD, sz, off, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        drive(IDL, 0, 0, 8'h00, 8'h00, 8'h00);
        check(rq, "rdata", reg_rdata, exp);
        check(rq, "err", {63'b0, reg_err}, 64'd0);
    endtask

    initial begin : watchdog
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "irq", {63'b0, irq_out}, 64'd0);
        check("R1", "err", {63'b0, reg_err}, 64'd0);
        read_chk(3'd3, 2'd0, 64'h00, "R1");

        for (int i = 0; i < NV; i++) begin
            logic [44:0] t;
            string rq;
            t = VECS[i];
            rq = $sformatf("R%0d", t[3:0]);
            drive(t[44:43], t[42:41], t[40:38], t[37:30], t[29:22], t[21:14]);
            @(negedge clk);
            check(rq, $sformatf("irq v%0d", i), {63'b0, irq_out}, {63'b0, t[13]});
            check(rq, $sformatf("err v%0d", i), {63'b0, reg_err}, {63'b0, t[12]});
            if (t[44:43] == RD)
                check(rq, $sformatf("rdata v%0d", i), reg_rdata, {56'b0, t[11:4]});
        end
        drive(IDL, 0, 0, 8'h00, 8'h00, 8'h00);

        // R6 64-bit read has zero upper bits with all lines pending
        @(negedge clk);
        drive(IDL, 0, 0, 8'h00, 8'hFF, 8'h00);
        @(negedge clk);
        drive(IDL, 0, 0, 8'h00, 8'h00, 8'h00);
        read_chk(3'd0, 2'd3, 64'h0000_0000_0000_00FF, "R6");
        read_chk(3'd0, 2'd0, 64'h0000_0000_0000_00FF, "R6");

        // R7 secondary mask of all ones still leaves output low when primary masked
        @(negedge clk);
        drive(WR, 0, 3'd3, 8'hFF, 8'h00, 8'h00);
        @(negedge clk);
        drive(IDL, 0, 0, 8'h00, 8'h00, 8'h00);
        check("R7", "irq", {63'b0, irq_out}, 64'd0);

        // R5 raise with pending, then R1 reset clears all
        @(negedge clk);
        drive(WR, 0, 3'd1, 8'h7F, 8'h00, 8'h00);
        @(negedge clk);
        drive(IDL, 0, 0, 8'h00, 8'h00, 8'h00);
        check("R5", "irq", {63'b0, irq_out}, 64'd1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "irq after reset", {63'b0, irq_out}, 64'd0);
        read_chk(3'd0, 2'd0, 64'h00, "R1");
        read_chk(3'd1, 2'd0, 64'hFF, "R1");
        read_chk(3'd3, 2'd0, 64'h00, "R1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule